// File: doc/BRIEF.md
# Clock-Ratio Speed-Mode Detector

This block runs entirely on the master clock of an audio converter and works out which sampling-speed band the incoming frame clock belongs to. It counts master-clock cycles between successive rising edges of the frame clock and matches the count against the seven ratios the converter supports. Two adjacent periods must agree before the detected band is adopted, and a ratio that matches nothing leaves the current band in place.

A select input lets the band come from the ratio (auto) or from an external two-bit mode code (manual). The de-emphasis request is passed on only while the selected band is normal speed. If the frame clock goes quiet for longer than a timeout, the block raises an internal reset for the downstream datapath. It drops that reset again once a recognised period has been measured. There is no streaming data path: all pins are plain control and status levels, with no valid/ready handshake and no back-pressure.

Top module: `spd_ratio_detect`

## Requirements
- R1: While and right after reset, `speed_mode` is 2'b00 (normal), `deemph_en` is 0 and `int_rst` is 1.
- R2: With `auto_sel` low, `speed_mode` follows `man_mode` one clock later: 2'b00 gives normal (2'b00), 2'b01 gives double (2'b01), 2'b10 gives quad (2'b10), and 2'b11 gives normal.
- R3: With `auto_sel` high, a measured period of 512, 768 or 1152 master cycles selects normal speed, encoded 2'b00.
- R4: With `auto_sel` high, a measured period of 256 or 384 master cycles selects double speed, encoded 2'b01.
- R5: With `auto_sel` high, a measured period of 128 or 192 master cycles selects quad speed, encoded 2'b10.
- R6: The measured period is the number of master cycles between two rising frame-clock edges. A period within ±8 cycles (inclusive) of a supported ratio is recognised. A period 9 cycles off is not.
- R7: The auto-detected mode changes only after two consecutive recognised periods give the same band. A single differing period leaves the mode unchanged.
- R8: An unrecognised period leaves the auto-detected mode as it was and breaks any run of agreeing periods.
- R9: When no rising frame-clock edge arrives for 2048 master cycles, `int_rst` goes high. It goes low again after the first recognised period that follows.
- R10: `deemph_en` equals `deemph_req` when the selected mode is normal and is 0 in double or quad. It is registered alongside `speed_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_clk | input | 1 | Frame (sample-rate) clock, synchronised internally |
| auto_sel | input | 1 | 1: band from clock ratio, 0: band from `man_mode` |
| man_mode | input | 2 | Manual band code |
| deemph_req | input | 1 | De-emphasis request |
| speed_mode | output | 2 | Selected band: 00 normal, 01 double, 10 quad |
| deemph_en | output | 1 | De-emphasis enable, gated by band |
| int_rst | output | 1 | Internal reset for the datapath |

## Verification
The assertions assume that `frame_clk` comes from the same master clock or changes slowly enough for the three-stage synchroniser to catch every level. They also assume each frame-clock half period lasts at least two master cycles. The stimulus meets both assumptions. It changes `frame_clk` only on falling master edges and uses half periods of 64 or more cycles. `auto_sel` and `man_mode` are held for many cycles at a time, so the one-cycle manual-follow property always sees a settled code.

// File: rtl/spd_pkg.sv
package spd_pkg;

  typedef enum logic [1:0] {
    SPD_NORMAL = 2'b00,
    SPD_DOUBLE = 2'b01,
    SPD_QUAD   = 2'b10
  } speed_t;

  localparam int unsigned NUM_RATIOS = 7;

  // Ratio in units of half the base ratio (base = quad-speed low ratio).
  function automatic int unsigned ratio_halves(input int unsigned idx);
    case (idx)
      0:       return 2;
      1:       return 3;
      2:       return 4;
      3:       return 6;
      4:       return 8;
      5:       return 12;
      default: return 18;
    endcase
  endfunction

  function automatic speed_t ratio_band(input int unsigned idx);
    if (idx < 2)      return SPD_QUAD;
    else if (idx < 4) return SPD_DOUBLE;
    else              return SPD_NORMAL;
  endfunction

  function automatic speed_t decode_manual(input logic [1:0] code);
    case (code)
      2'b01:   return SPD_DOUBLE;
      2'b10:   return SPD_QUAD;
      default: return SPD_NORMAL;
    endcase
  endfunction

endpackage

// File: rtl/spd_edge_sync.sv
module spd_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], async_in};
  end

  assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/spd_period_meter.sv
module spd_period_meter #(
  parameter int unsigned TIMEOUT = 2048,
  localparam int unsigned CW = $clog2(TIMEOUT + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise,
  output logic          meas_valid,
  output logic [CW-1:0] meas_val,
  output logic          stall
);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT);

  logic [CW-1:0] cnt;
  logic          seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      seen       <= 1'b0;
      meas_valid <= 1'b0;
      meas_val   <= '0;
    end else begin
      meas_valid <= rise & seen;
      if (rise) begin
        meas_val <= cnt + 1'b1;
        cnt      <= '0;
        seen     <= 1'b1;
      end else if (cnt != LIMIT) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign stall = (cnt == LIMIT);
endmodule

// File: rtl/spd_ratio_classify.sv
module spd_ratio_classify
  import spd_pkg::*;
#(
  parameter int unsigned BASE_RATIO = 128,
  parameter int unsigned TOL        = 8,
  parameter int unsigned CW         = 12
) (
  input  logic [CW-1:0] meas_val,
  output logic          class_ok,
  output speed_t        class_band
);
  logic [NUM_RATIOS-1:0] hit;

  for (genvar i = 0; i < NUM_RATIOS; i++) begin : g_win
    localparam int unsigned NOM = BASE_RATIO * ratio_halves(i) / 2;
    localparam logic [CW-1:0] LO = CW'(NOM - TOL);
    localparam logic [CW-1:0] HI = CW'(NOM + TOL);
    assign hit[i] = (meas_val >= LO) && (meas_val <= HI);
  end

  always_comb begin
    logic [1:0] acc;
    acc = 2'b00;
    for (int i = 0; i < NUM_RATIOS; i++) begin
      if (hit[i]) acc = acc | ratio_band(i);
    end
    class_ok   = |hit;
    class_band = speed_t'(acc);
  end
endmodule

// File: rtl/spd_mode_select.sv
module spd_mode_select
  import spd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       meas_valid,
  input  logic       class_ok,
  input  speed_t     class_band,
  input  logic       stall,
  input  logic       auto_sel,
  input  logic [1:0] man_mode,
  input  logic       deemph_req,
  output speed_t     mode_q,
  output logic       deemph_q,
  output logic       irst_q
);
  speed_t auto_band;
  speed_t cand;
  logic   cand_ok;
  speed_t nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      auto_band <= SPD_NORMAL;
      cand      <= SPD_NORMAL;
      cand_ok   <= 1'b0;
    end else if (meas_valid) begin
      if (class_ok) begin
        if (cand_ok && cand == class_band) auto_band <= class_band;
        cand    <= class_band;
        cand_ok <= 1'b1;
      end else begin
        cand_ok <= 1'b0;
      end
    end else if (stall) begin
      cand_ok <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       irst_q <= 1'b1;
    else if (stall)                   irst_q <= 1'b1;
    else if (meas_valid && class_ok)  irst_q <= 1'b0;
  end

  assign nxt = auto_sel ? auto_band : decode_manual(man_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= SPD_NORMAL;
      deemph_q <= 1'b0;
    end else begin
      mode_q   <= nxt;
      deemph_q <= deemph_req && (nxt == SPD_NORMAL);
    end
  end

  AST_HOLD_ON_UNRECOGNISED: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_valid && !class_ok) |=> $stable(auto_band)); // R8
  AST_CHANGE_NEEDS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(auto_band) |-> ($past(cand_ok) && $past(cand) == auto_band)); // R7
  AST_STALL_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> irst_q); // R9
endmodule

// File: rtl/spd_ratio_detect.sv
module spd_ratio_detect
  import spd_pkg::*;
#(
  parameter int unsigned BASE_RATIO  = 128,
  parameter int unsigned TOL         = 8,
  parameter int unsigned TIMEOUT     = 2048,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_clk,
  input  logic       auto_sel,
  input  logic [1:0] man_mode,
  input  logic       deemph_req,
  output logic [1:0] speed_mode,
  output logic       deemph_en,
  output logic       int_rst
);
  localparam int unsigned CW = $clog2(TIMEOUT + 2);

  logic          rise;
  logic          meas_valid;
  logic [CW-1:0] meas_val;
  logic          stall;
  logic          class_ok;
  speed_t        class_band;
  speed_t        mode_q;

  spd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(frame_clk), .rise(rise)
  );

  spd_period_meter #(.TIMEOUT(TIMEOUT)) u_meter (
    .clk(clk), .rst_n(rst_n), .rise(rise),
    .meas_valid(meas_valid), .meas_val(meas_val), .stall(stall)
  );

  spd_ratio_classify #(.BASE_RATIO(BASE_RATIO), .TOL(TOL), .CW(CW)) u_class (
    .meas_val(meas_val), .class_ok(class_ok), .class_band(class_band)
  );

  spd_mode_select u_sel (
    .clk(clk), .rst_n(rst_n), .meas_valid(meas_valid), .class_ok(class_ok),
    .class_band(class_band), .stall(stall), .auto_sel(auto_sel),
    .man_mode(man_mode), .deemph_req(deemph_req),
    .mode_q(mode_q), .deemph_q(deemph_en), .irst_q(int_rst)
  );

  assign speed_mode = mode_q;

  AST_DEEMPH_NORMAL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    deemph_en |-> (speed_mode == SPD_NORMAL)); // R10
  AST_MANUAL_DOUBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_sel && man_mode == 2'b01) |=> (speed_mode == SPD_DOUBLE)); // R2
  AST_MANUAL_QUAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_sel && man_mode == 2'b10) |=> (speed_mode == SPD_QUAD)); // R2
endmodule

// File: tb/tb_spd_ratio_detect.sv
module tb_spd_ratio_detect;
  localparam int TO  = 2048;
  localparam int TOL = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_clk = 1'b0;
  logic       auto_sel = 1'b1;
  logic [1:0] man_mode = 2'b00;
  logic       deemph_req = 1'b0;
  logic [1:0] speed_mode;
  logic       deemph_en;
  logic       int_rst;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  spd_ratio_detect dut (
    .clk(clk), .rst_n(rst_n), .frame_clk(frame_clk), .auto_sel(auto_sel),
    .man_mode(man_mode), .deemph_req(deemph_req),
    .speed_mode(speed_mode), .deemph_en(deemph_en), .int_rst(int_rst)
  );

  // ---------------- behavioural reference model ----------------
  bit hist[$] = '{0, 0, 0};
  int m_age = 0, m_pend = -1, m_auto = 0, m_cand = 0, m_mode = 0;
  bit m_seen = 0, m_cand_ok = 0, m_irst = 1, m_de = 0;

  function automatic int classify(input int p);
    int noms[7] = '{128, 192, 256, 384, 512, 768, 1152};
    int bands[7] = '{2, 2, 1, 1, 0, 0, 0};
    for (int i = 0; i < 7; i++) begin
      int d = p - noms[i];
      if (d < 0) d = -d;
      if (d <= TOL) return bands[i];
    end
    return -1;
  endfunction

  function automatic int man_band(input logic [1:0] c);
    if (c == 2'b01) return 1;
    if (c == 2'b10) return 2;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = '{0, 0, 0};
      m_age = 0; m_pend = -1; m_auto = 0; m_cand = 0; m_mode = 0;
      m_seen = 0; m_cand_ok = 0; m_irst = 1; m_de = 0;
    end else begin
      int nm, c;
      bit stalled, edge_seen;
      nm = auto_sel ? m_auto : man_band(man_mode);
      stalled = (m_age == TO);
      if (m_pend >= 0) begin
        c = classify(m_pend);
        if (c >= 0) begin
          if (m_cand_ok && m_cand == c) m_auto = c;
          m_cand = c; m_cand_ok = 1; m_irst = 0;
        end else m_cand_ok = 0;
      end else if (stalled) m_cand_ok = 0;
      if (stalled) m_irst = 1;
      m_mode = nm;
      m_de = deemph_req && (nm == 0);
      edge_seen = hist[1] && !hist[2];
      m_pend = (edge_seen && m_seen) ? m_age + 1 : -1;
      if (edge_seen) begin m_age = 0; m_seen = 1; end
      else if (m_age < TO) m_age++;
      hist.push_front(frame_clk);
      void'(hist.pop_back());
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      check("R7 speed_mode vs model", int'(speed_mode), m_mode);
      check("R10 deemph_en vs model", int'(deemph_en), int'(m_de));
      check("R9 int_rst vs model", int'(int_rst), int'(m_irst));
    end
  end

  task automatic frames(input int n, input int k);
    for (int f = 0; f < k; f++) begin
      frame_clk = 1'b1;
      repeat (n / 2) @(negedge clk);
      frame_clk = 1'b0;
      repeat (n - n / 2) @(negedge clk);
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check("R1 reset speed_mode", int'(speed_mode), 0);
    check("R1 reset deemph_en", int'(deemph_en), 0);
    check("R1 reset int_rst", int'(int_rst), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release int_rst", int'(int_rst), 1);

    deemph_req = 1'b1;
    frames(512, 4);
    check("R3 512 normal", int'(speed_mode), 0);
    check("R10 normal passes deemph", int'(deemph_en), 1);
    check("R9 recognised clears int_rst", int'(int_rst), 0);
    frames(256, 4);
    check("R4 256 double", int'(speed_mode), 1);
    check("R10 double forces deemph off", int'(deemph_en), 0);
    frames(128, 4);
    check("R5 128 quad", int'(speed_mode), 2);
    frames(384, 4);
    check("R4 384 double", int'(speed_mode), 1);
    frames(192, 4);
    check("R5 192 quad", int'(speed_mode), 2);
    check("R10 quad forces deemph off", int'(deemph_en), 0);
    frames(768, 4);
    check("R3 768 normal", int'(speed_mode), 0);
    frames(256, 4);
    frames(1152, 4);
    check("R3 1152 normal", int'(speed_mode), 0);
    frames(256, 4);
    frames(1160, 4);
    check("R6 +8 tolerance accepted", int'(speed_mode), 0);
    frames(256, 4);
    frames(1161, 3);
    check("R6 +9 rejected mode held", int'(speed_mode), 1);
    frames(760, 4);
    check("R6 -8 tolerance accepted", int'(speed_mode), 0);
    frames(256, 4);
    frames(640, 4);
    check("R8 unrecognised holds double", int'(speed_mode), 1);
    frames(256, 2);
    frames(128, 1);
    frames(256, 1);
    check("R7 single quad period ignored", int'(speed_mode), 1);
    frames(256, 3);
    check("R7 still double", int'(speed_mode), 1);

    frames(512, 1);
    repeat (2500) @(negedge clk);
    check("R9 stall raises int_rst", int'(int_rst), 1);
    frames(512, 4);
    check("R9 int_rst cleared after restart", int'(int_rst), 0);
    check("R3 normal after restart", int'(speed_mode), 0);

    auto_sel = 1'b0;
    man_mode = 2'b01;
    repeat (2) @(negedge clk);
    check("R2 manual 01 double", int'(speed_mode), 1);
    man_mode = 2'b10;
    repeat (2) @(negedge clk);
    check("R2 manual 10 quad", int'(speed_mode), 2);
    check("R10 manual quad deemph off", int'(deemph_en), 0);
    man_mode = 2'b11;
    repeat (2) @(negedge clk);
    check("R2 manual 11 normal", int'(speed_mode), 0);
    check("R10 manual normal deemph on", int'(deemph_en), 1);
    man_mode = 2'b00;
    repeat (2) @(negedge clk);
    check("R2 manual 00 normal", int'(speed_mode), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired R1 actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule